// File: doc/BRIEF.md
# Paged Indirect Word Bridge

This block lets a host that only has a small file of 16-bit management registers reach a wide 32-bit internal address space. A page register selects which set of registers the host sees; when it holds the extended page number, a group of bridge registers appears. These hold a mode flag, a write address, write data, a read address and read data. The address and data registers are each split into a high half and a low half.

The host writes the high half of a data word first and then the low half. Writing the low half sends one full 32-bit write to the backend port. Writing the low half of the read address starts a 32-bit backend read. The returned word is kept until the next read finishes, so the two read-data halves always belong to the same word.

When auto-increment is on, every committed write moves the write address forward by one word. A long image can then be streamed by setting the address once and sending data pairs. The backend is a plain request/acknowledge port. A commit that arrives while a transfer is still in flight is held in a one-entry slot and issued as soon as the port is free.

Top module: `pgbr_bridge`

## Requirements
- R1: After reset the page register reads 0, the mode flag is clear, busy and mem_req are low, and reg_rdata is 0.
- R2: Register 0x1f is the page register on every page. A read of it returns the last 16-bit value written.
- R3: While the page register holds any value other than 4, writes to 0x10..0x18 change no state and start no backend transfer, and reads of those addresses return 0.
- R4: On page 4, register 0x10 holds the mode flag in bit 15 (1 means auto-increment, 0 means fixed address). It reads back as 0x8000 or 0x0000.
- R5: A write to the write-data high register (0x13) only latches the half word. No backend transfer is started.
- R6: A write to the write-data low register (0x14) issues one backend write. The data is {latched 0x13 value, written value}, with the high half in bits 31:16. The address is {0x11, 0x12}.
- R7: In auto-increment mode, each committed write advances the write address by 4, with carry from the low register into the high register. The advanced address reads back through 0x11/0x12.
- R8: In fixed mode, repeated commits all go to the same address, and 0x11/0x12 keep their values.
- R9: A write to 0x16 starts a backend read at {0x15, written value}. After completion, 0x17 returns bits 31:16 and 0x18 returns bits 15:0 of the returned word.
- R10: The returned read word is held unchanged until the next backend read completes, and backend writes do not disturb it.
- R11: busy is high from the cycle after a commit until every pending transfer has been acknowledged. A commit that arrives during a transfer is held and then issued in order.
- R12: mem_req stays high, with mem_addr, mem_we and mem_wdata unchanged, until mem_ack is seen.
- R13: reg_rdata is registered. It takes the addressed value one cycle after a reg_rd strobe and holds it otherwise. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 5 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered host read data |
| busy | output | 1 | A backend transfer is pending or in flight |
| mem_req | output | 1 | Backend request |
| mem_we | output | 1 | Backend write (1) or read (0) |
| mem_addr | output | 32 | Backend byte address |
| mem_wdata | output | 32 | Backend write data |
| mem_ack | input | 1 | Backend acknowledge |
| mem_rdata | input | 32 | Backend read data, valid with mem_ack |

## Verification
The assertions assume that the host issues at most one commit while a transfer is in flight, since the hold slot has a single entry. They also assume that the backend raises mem_ack only while mem_req is high. The bench's backend model acknowledges only requests it sees, after a programmable latency. Streaming pairs run with zero latency, and under long latency the bench sends exactly one extra commit before waiting for busy to fall. Timing checks cover that the request holds steady and that busy covers both the held commit and the in-flight one.

// File: rtl/pgbr_pkg.sv
package pgbr_pkg;
  // Register offsets; the page register is visible on every page.
  localparam int unsigned RG_MODE  = 'h10;
  localparam int unsigned RG_WA_HI = 'h11;
  localparam int unsigned RG_WA_LO = 'h12;
  localparam int unsigned RG_WD_HI = 'h13;
  localparam int unsigned RG_WD_LO = 'h14;
  localparam int unsigned RG_RA_HI = 'h15;
  localparam int unsigned RG_RA_LO = 'h16;
  localparam int unsigned RG_RD_HI = 'h17;
  localparam int unsigned RG_RD_LO = 'h18;
  localparam int unsigned RG_PAGE  = 'h1f;

  typedef enum logic {XF_IDLE, XF_WAIT} xf_state_e;
endpackage

// File: rtl/pgbr_hostregs.sv
module pgbr_hostregs
  import pgbr_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned EXT_PAGE  = 4,
  parameter int unsigned ADDR_STEP = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [HALF_W-1:0]     reg_wdata,
  input  logic [2*HALF_W-1:0]   rd_word,
  output logic [HALF_W-1:0]     reg_rdata,
  output logic                  cmd_push,
  output logic                  cmd_we,
  output logic [2*HALF_W-1:0]   cmd_addr,
  output logic [2*HALF_W-1:0]   cmd_wdata
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] page_q;
  logic              incr_q;
  logic [WORD_W-1:0] wa_q;
  logic [HALF_W-1:0] wd_hi_q;
  logic [WORD_W-1:0] ra_q;
  logic              on_ext;
  logic              bw;
  logic              wr_commit;
  logic              rd_start;
  logic [HALF_W-1:0] rd_mux;

  assign on_ext    = (page_q == HALF_W'(EXT_PAGE));
  assign bw        = reg_wr && on_ext;
  assign wr_commit = bw && (reg_addr == REG_AW'(RG_WD_LO));
  assign rd_start  = bw && (reg_addr == REG_AW'(RG_RA_LO));

  assign cmd_push  = wr_commit || rd_start;
  assign cmd_we    = wr_commit;
  assign cmd_addr  = wr_commit ? wa_q : {ra_q[WORD_W-1:HALF_W], reg_wdata};
  assign cmd_wdata = {wd_hi_q, reg_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      incr_q  <= 1'b0;
      wa_q    <= '0;
      wd_hi_q <= '0;
      ra_q    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == REG_AW'(RG_PAGE)) begin
        page_q <= reg_wdata;
      end else if (on_ext) begin
        case (reg_addr)
          REG_AW'(RG_MODE):  incr_q <= reg_wdata[HALF_W-1];
          REG_AW'(RG_WA_HI): wa_q[WORD_W-1:HALF_W] <= reg_wdata;
          REG_AW'(RG_WA_LO): wa_q[HALF_W-1:0] <= reg_wdata;
          REG_AW'(RG_WD_HI): wd_hi_q <= reg_wdata;
          REG_AW'(RG_WD_LO): if (incr_q) wa_q <= wa_q + WORD_W'(ADDR_STEP);
          REG_AW'(RG_RA_HI): ra_q[WORD_W-1:HALF_W] <= reg_wdata;
          REG_AW'(RG_RA_LO): ra_q[HALF_W-1:0] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(RG_PAGE)) begin
      rd_mux = page_q;
    end else if (on_ext) begin
      case (reg_addr)
        REG_AW'(RG_MODE):  rd_mux = {incr_q, {(HALF_W-1){1'b0}}};
        REG_AW'(RG_WA_HI): rd_mux = wa_q[WORD_W-1:HALF_W];
        REG_AW'(RG_WA_LO): rd_mux = wa_q[HALF_W-1:0];
        REG_AW'(RG_WD_HI): rd_mux = wd_hi_q;
        REG_AW'(RG_RA_HI): rd_mux = ra_q[WORD_W-1:HALF_W];
        REG_AW'(RG_RA_LO): rd_mux = ra_q[HALF_W-1:0];
        REG_AW'(RG_RD_HI): rd_mux = rd_word[WORD_W-1:HALF_W];
        REG_AW'(RG_RD_LO): rd_mux = rd_word[HALF_W-1:0];
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // Off-page bridge writes leave the bridge state untouched.
  assert_offpage_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !on_ext && reg_addr != REG_AW'(RG_PAGE))
      |=> ($stable(wa_q) && $stable(ra_q) && $stable(incr_q) && $stable(wd_hi_q)));

  // Fixed mode keeps the write address across a commit.
  assert_fixed_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !incr_q) |=> $stable(wa_q));
endmodule

// File: rtl/pgbr_hold.sv
module pgbr_hold #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_we,
  input  logic [WORD_W-1:0] push_addr,
  input  logic [WORD_W-1:0] push_wdata,
  input  logic              pop,
  output logic              slot_v,
  output logic              slot_we,
  output logic [WORD_W-1:0] slot_addr,
  output logic [WORD_W-1:0] slot_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v     <= 1'b0;
      slot_we    <= 1'b0;
      slot_addr  <= '0;
      slot_wdata <= '0;
    end else if (push) begin
      slot_v     <= 1'b1;
      slot_we    <= push_we;
      slot_addr  <= push_addr;
      slot_wdata <= push_wdata;
    end else if (pop) begin
      slot_v <= 1'b0;
    end
  end

  // The host never commits into a full slot that is not draining this cycle.
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    (push && slot_v) |-> pop);
endmodule

// File: rtl/pgbr_xfer.sv
module pgbr_xfer
  import pgbr_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_v,
  input  logic              slot_we,
  input  logic [WORD_W-1:0] slot_addr,
  input  logic [WORD_W-1:0] slot_wdata,
  output logic              pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] rd_word
);
  xf_state_e st_q;

  assign mem_req = (st_q == XF_WAIT);
  assign pop     = slot_v && (st_q == XF_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= XF_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_word   <= '0;
    end else begin
      case (st_q)
        XF_IDLE: if (slot_v) begin
          st_q      <= XF_WAIT;
          mem_we    <= slot_we;
          mem_addr  <= slot_addr;
          mem_wdata <= slot_wdata;
        end
        XF_WAIT: if (mem_ack) begin
          st_q <= XF_IDLE;
          if (!mem_we) rd_word <= mem_rdata;
        end
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_ack && !mem_we) |=> $stable(rd_word));
endmodule

// File: rtl/pgbr_bridge.sv
module pgbr_bridge #(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned EXT_PAGE  = 4,
  parameter int unsigned ADDR_STEP = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [HALF_W-1:0]     reg_wdata,
  output logic [HALF_W-1:0]     reg_rdata,
  output logic                  busy,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [2*HALF_W-1:0]   mem_addr,
  output logic [2*HALF_W-1:0]   mem_wdata,
  input  logic                  mem_ack,
  input  logic [2*HALF_W-1:0]   mem_rdata
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              cmd_push;
  logic              cmd_we;
  logic [WORD_W-1:0] cmd_addr;
  logic [WORD_W-1:0] cmd_wdata;
  logic              slot_v;
  logic              slot_we;
  logic [WORD_W-1:0] slot_addr;
  logic [WORD_W-1:0] slot_wdata;
  logic              pop;
  logic [WORD_W-1:0] rd_word;

  pgbr_hostregs #(
    .HALF_W(HALF_W), .REG_AW(REG_AW), .EXT_PAGE(EXT_PAGE), .ADDR_STEP(ADDR_STEP)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_word(rd_word), .reg_rdata(reg_rdata),
    .cmd_push(cmd_push), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
  );

  pgbr_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .push(cmd_push), .push_we(cmd_we), .push_addr(cmd_addr),
    .push_wdata(cmd_wdata), .pop(pop), .slot_v(slot_v), .slot_we(slot_we),
    .slot_addr(slot_addr), .slot_wdata(slot_wdata)
  );

  pgbr_xfer #(.WORD_W(WORD_W)) u_xfer (
    .clk(clk), .rst(rst), .slot_v(slot_v), .slot_we(slot_we), .slot_addr(slot_addr),
    .slot_wdata(slot_wdata), .pop(pop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rd_word(rd_word)
  );

  assign busy = slot_v || mem_req;

  assert_commit_busy_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_push |=> busy);
endmodule

// File: tb/pgbr_bridge_tb.sv
module pgbr_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int cnt = 0;
  int nwr = 0;
  int cyc = 0;
  logic [31:0] mem [256];
  logic [31:0] wlog_a [16];
  logic [31:0] wlog_d [16];

  always #4 clk = ~clk;

  pgbr_bridge u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // Backend model: acknowledges a seen request after lat extra cycles.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      cnt = 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        cnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          if (nwr < 16) begin
            wlog_a[nwr] = mem_addr;
            wlog_d[nwr] = mem_wdata;
          end
          nwr = nwr + 1;
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
        end
      end else begin
        cnt = cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [4:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  typedef struct packed {
    logic        rd;
    logic [4:0]  a;
    logic [15:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'h1f, 16'h0004, 4'd2},
    '{1'b1, 5'h1f, 16'h0004, 4'd2},   // R2 page readback
    '{1'b0, 5'h10, 16'hffff, 4'd4},
    '{1'b1, 5'h10, 16'h8000, 4'd4},   // R4 only bit 15 kept
    '{1'b0, 5'h10, 16'h7fff, 4'd4},
    '{1'b1, 5'h10, 16'h0000, 4'd4},   // R4 fixed mode
    '{1'b0, 5'h11, 16'h00ab, 4'd13},
    '{1'b0, 5'h12, 16'hcd00, 4'd13},
    '{1'b1, 5'h11, 16'h00ab, 4'd13},  // R13 readback
    '{1'b1, 5'h12, 16'hcd00, 4'd13},
    '{1'b1, 5'h1a, 16'h0000, 4'd13},  // R13 unused address
    '{1'b0, 5'h1f, 16'h0000, 4'd3},
    '{1'b0, 5'h11, 16'h5555, 4'd3},   // R3 ignored
    '{1'b0, 5'h14, 16'h1234, 4'd3},   // R3 no commit
    '{1'b1, 5'h11, 16'h0000, 4'd3},   // R3 reads 0 off page
    '{1'b1, 5'h1f, 16'h0000, 4'd2},
    '{1'b0, 5'h1f, 16'h0004, 4'd3},
    '{1'b1, 5'h11, 16'h00ab, 4'd3},   // R3 value kept
    '{1'b1, 5'h10, 16'h0000, 4'd3}
  };

  initial begin : watchdog
    while (cyc < 20000) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] rv;
    logic [15:0] rh;
    int n0;
    int drops;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 reg_rdata", 32'(reg_rdata), 32'd0);
    hrd(5'h1f, rv);
    check("R1 page", 32'(rv), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        hrd(TBL[i].a, rv);
        total = total + 1;
        if (rv !== TBL[i].d) begin
          bad = bad + 1;
          $display("FAIL R%0d row %0d actual=%h expected=%h", TBL[i].req, i, rv, TBL[i].d);
        end
      end else begin
        hwr(TBL[i].a, TBL[i].d);
      end
    end
    check("R3 no transfer off page", 32'(nwr), 32'd0);

    // R5 high half alone
    hwr(5'h13, 16'hbeef);
    repeat (4) @(negedge clk);
    check("R5 no write", 32'(nwr), 32'd0);
    check("R5 busy low", 32'(busy), 32'd0);

    // R6 commit, R11 busy next cycle
    hwr(5'h14, 16'h1234);
    check("R11 busy after commit", 32'(busy), 32'd1);
    wait_idle();
    check("R6 count", 32'(nwr), 32'd1);
    check("R6 addr", wlog_a[0], 32'h00abcd00);
    check("R6 data", wlog_d[0], 32'hbeef1234);

    // R8 fixed mode, back-to-back pairs
    hwr(5'h13, 16'h1111); hwr(5'h14, 16'h2222);
    hwr(5'h13, 16'h3333); hwr(5'h14, 16'h4444);
    wait_idle();
    check("R8 addr a", wlog_a[1], 32'h00abcd00);
    check("R8 addr b", wlog_a[2], 32'h00abcd00);
    check("R8 data b", wlog_d[2], 32'h33334444);
    hrd(5'h12, rv);
    check("R8 addr reg", 32'(rv), 32'h0000cd00);

    // R7 streaming with carry into the high half
    hwr(5'h10, 16'h8000);
    hwr(5'h11, 16'h0001); hwr(5'h12, 16'hfff8);
    hwr(5'h13, 16'ha0a0); hwr(5'h14, 16'h0001);
    hwr(5'h13, 16'hb1b1); hwr(5'h14, 16'h0002);
    hwr(5'h13, 16'hc2c2); hwr(5'h14, 16'h0003);
    wait_idle();
    check("R7 addr 0", wlog_a[3], 32'h0001fff8);
    check("R7 addr 1", wlog_a[4], 32'h0001fffc);
    check("R7 addr 2", wlog_a[5], 32'h00020000);
    check("R7 data 2", wlog_d[5], 32'hc2c20003);
    hrd(5'h11, rh);
    hrd(5'h12, rv);
    check("R7 addr reg", {rh, rv}, 32'h00020004);
    hwr(5'h10, 16'h0000);

    // R9 read
    hwr(5'h15, 16'h0001); hwr(5'h16, 16'hfffc);
    check("R11 busy read", 32'(busy), 32'd1);
    wait_idle();
    hrd(5'h17, rh);
    hrd(5'h18, rv);
    check("R9 read word", {rh, rv}, 32'hb1b10002);
    hrd(5'h16, rv);
    check("R9 read addr reg", 32'(rv), 32'h0000fffc);

    // R10 writes leave the read word alone
    hwr(5'h13, 16'h5555); hwr(5'h14, 16'h6666);
    wait_idle();
    hrd(5'h17, rh);
    hrd(5'h18, rv);
    check("R10 held word", {rh, rv}, 32'hb1b10002);
    hwr(5'h15, 16'h0002); hwr(5'h16, 16'h0000);
    wait_idle();
    hrd(5'h17, rh);
    hrd(5'h18, rv);
    check("R10 new word", {rh, rv}, 32'hc2c20003);

    // R11 / R12 held commit under long latency
    lat = 6;
    hwr(5'h10, 16'h8000);
    n0 = nwr;
    hwr(5'h13, 16'h7777); hwr(5'h14, 16'h8888);
    hwr(5'h13, 16'h9999); hwr(5'h14, 16'haaaa);
    check("R11 busy held", 32'(busy), 32'd1);
    check("R11 none done yet", 32'(nwr), 32'(n0));
    repeat (2) @(negedge clk);
    check("R12 req held", 32'(mem_req), 32'd1);
    check("R12 no early write", 32'(nwr), 32'(n0));
    drops = 0;
    for (int k = 0; k < 40; k++) begin
      if (nwr < n0 + 2 && !busy) drops = drops + 1;
      @(negedge clk);
    end
    check("R11 busy gapless", 32'(drops), 32'd0);
    check("R11 both done", 32'(nwr), 32'(n0 + 2));
    check("R11 first addr", wlog_a[n0], 32'h00020004);
    check("R11 first data", wlog_d[n0], 32'h77778888);
    check("R11 second addr", wlog_a[n0+1], 32'h00020008);
    check("R11 second data", wlog_d[n0+1], 32'h9999aaaa);
    check("R11 busy low", 32'(busy), 32'd0);

    // R13 read data holds without a strobe
    hrd(5'h1f, rv);
    repeat (3) @(negedge clk);
    check("R13 rdata held", 32'(reg_rdata), 32'h00000004);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule